// File: doc/BRIEF.md
# Programmable Raster Timing Sequencer

This block produces video raster timing by running a small program instead of comparing fixed horizontal and vertical counters against limit registers. Software writes a program of 32-bit words into an on-chip store while the block is held in reset. Once reset is released, the block runs one word per pixel clock starting at address 0. Each word drives the four timing lines directly from its top nibble. The word can also hold the lines for a counted number of cycles, call a subroutine a counted number of times, jump, return, raise an interrupt, emit a fixed pixel, or pass a command to a neighbouring fetch or pixel unit.

Any line length, frame height, porch or serration pattern can therefore be written as code. Each branch, call and return takes one clock cycle of its own, and the program's cycle budget must include those cycles. Nested calls use a four-level stack. Each stack level holds a return address, the subroutine entry and the number of passes still to run.

Top module: `raster_seq`

## Requirements
- R1: While `rst_n` is low, every output is 0 and load-port writes store `ld_data` at `ld_addr`. Execution starts at address 0, and the first word's effect appears on the outputs two clock edges after `rst_n` rises.
- R2: Bits 31, 30, 29 and 28 of the executing word drive `hsync`, `vsync`, `active` and `aux` for every cycle that the word executes.
- R3: A word with opcode (bits 27:25) equal to 0 holds for N cycles, where N is taken from bits 12:0. A count of 0 behaves like 1.
- R4: Opcode 1 takes one cycle and then runs the subroutine at bits 8:0 the number of times given in bits 22:9 (0 behaves like 1). Execution then resumes at the word after the call.
- R5: Opcode 2 with bit 24 set is a return and takes one cycle. If passes remain, it goes back to the subroutine entry. Otherwise it resumes at the saved return address. A return with an empty stack moves on to the next word.
- R6: Calls nest correctly up to four levels deep.
- R7: Opcode 2 with bit 24 clear takes one cycle and continues at the address in bits 8:0.
- R8: Opcode 3 with bit 24 clear raises `irq` for exactly the one cycle of that word.
- R9: Opcode 3 with bit 24 set raises `pix_valid` for one cycle, with `pix_data` equal to bits 23:0. `pix_data` is 0 in all other cycles.
- R10: Opcodes 4 to 7 raise `cmd_valid` for one cycle and then move on without a stall. `cmd_kind` is the opcode minus 4: 0 sets an address, 1 increments an address, 2 gives a fetch count and 3 gives a send count. `cmd_arg` equals bits 24:0. `cmd_kind` and `cmd_arg` are 0 in all other cycles.
- R11: A load-port write made while the program is running has no effect on the stored program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| ld_we | input | 1 | Program word write strobe (accepted in reset only) |
| ld_addr | input | 9 | Program word address |
| ld_data | input | 32 | Program word |
| hsync | output | 1 | Horizontal sync from bit 31 |
| vsync | output | 1 | Vertical sync from bit 30 |
| active | output | 1 | Active video from bit 29 |
| aux | output | 1 | Spare line from bit 28 |
| irq | output | 1 | Interrupt pulse |
| pix_valid | output | 1 | Fixed-pixel strobe |
| pix_data | output | 24 | Fixed pixel value |
| cmd_valid | output | 1 | Neighbour command strobe |
| cmd_kind | output | 2 | Command type, opcode minus 4 |
| cmd_arg | output | 25 | Command data field |

## Verification
All outputs are decoded without a register from the word at the current program address. A word's timing lines and strobes therefore appear in the same cycle that the word executes. After `rst_n` rises, two synchroniser edges pass before address 0 appears. Every later word appears one edge after the edge that selected its address. The bench's reference model advances once per rising edge, using the same two-edge start delay. Outputs are sampled and compared on each falling edge, so any stalled, extra or missing cycle in a hold, call, return or jump shows up as a mismatch in that same cycle.

// File: rtl/raster_seq_pkg.sv
package raster_seq_pkg;
  localparam int WORD_W = 32;
  localparam int NOP_W  = 13;
  localparam int CNT_W  = 14;
  localparam int PIX_W  = 24;
  localparam int ARG_W  = 25;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_CALL   = 3'd1,
    OP_BRANCH = 3'd2,
    OP_EVENT  = 3'd3,
    OP_ADDR   = 3'd4,
    OP_INC    = 3'd5,
    OP_FETCH  = 3'd6,
    OP_SEND   = 3'd7
  } op_e;
endpackage

// File: rtl/raster_prog_mem.sv
module raster_prog_mem #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/raster_ret_stack.sv
module raster_ret_stack #(
  parameter int DEPTH = 4,
  parameter int AW    = 9,
  parameter int CW    = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic          dec,
  input  logic [AW-1:0] push_ret,
  input  logic [AW-1:0] push_tgt,
  input  logic [CW-1:0] push_cnt,
  output logic [AW-1:0] top_ret,
  output logic [AW-1:0] top_tgt,
  output logic [CW-1:0] top_cnt,
  output logic          empty,
  output logic          full
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SPW-1:0] sp_q, sp_d;
  logic [IW-1:0]  wr_idx, top_idx;
  logic [AW-1:0]  ret_q [DEPTH];
  logic [AW-1:0]  tgt_q [DEPTH];
  logic [CW-1:0]  cnt_q [DEPTH];

  assign empty   = (sp_q == '0);
  assign full    = (sp_q == SPW'(DEPTH));
  assign wr_idx  = IW'(sp_q);
  assign top_idx = IW'(sp_q - SPW'(1));
  assign top_ret = ret_q[top_idx];
  assign top_tgt = tgt_q[top_idx];
  assign top_cnt = cnt_q[top_idx];

  always_comb begin
    sp_d = sp_q;
    if (clr) begin
      sp_d = '0;
    end else if (push && !full) begin
      sp_d = sp_q + SPW'(1);
    end else if (pop && !empty) begin
      sp_d = sp_q - SPW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else begin
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!clr && push && !full && wr_idx == IW'(i)) begin
        ret_q[i] <= push_ret;
        tgt_q[i] <= push_tgt;
        cnt_q[i] <= push_cnt;
      end else if (!clr && dec && !empty && top_idx == IW'(i)) begin
        cnt_q[i] <= cnt_q[i] - CW'(1);
      end
    end
  end

  // R6
  stk_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R5
  stk_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop || dec) |-> !empty);
endmodule

// File: rtl/raster_seq.sv
module raster_seq
  import raster_seq_pkg::*;
#(
  parameter int PC_W        = 9,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [PC_W-1:0]   ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic              hsync,
  output logic              vsync,
  output logic              active,
  output logic              aux,
  output logic              irq,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_data,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic [ARG_W-1:0]  cmd_arg
);
  logic [1:0]        rsync_q;
  logic              run;
  logic [WORD_W-1:0] rd_word, word;
  op_e               op;
  logic              sel24;
  logic [NOP_W-1:0]  nop_n;
  logic [CNT_W-1:0]  call_n, push_cnt;
  logic [PC_W-1:0]   tgt, pc_inc;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic              busy_q, busy_d;
  logic [NOP_W-1:0]  left_q, left_d;
  logic              push, pop, dec;
  logic [PC_W-1:0]   top_ret, top_tgt;
  logic [CNT_W-1:0]  top_cnt;
  logic              st_empty, st_full;

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign run = rsync_q[1];

  raster_prog_mem #(.AW(PC_W), .DW(WORD_W)) u_mem (
    .clk   (clk),
    .we    (ld_we && !run),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc_q),
    .rdata (rd_word)
  );

  raster_ret_stack #(.DEPTH(STACK_DEPTH), .AW(PC_W), .CW(CNT_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!run),
    .push     (push),
    .pop      (pop),
    .dec      (dec),
    .push_ret (pc_inc),
    .push_tgt (tgt),
    .push_cnt (push_cnt),
    .top_ret  (top_ret),
    .top_tgt  (top_tgt),
    .top_cnt  (top_cnt),
    .empty    (st_empty),
    .full     (st_full)
  );

  // instruction field decode
  assign word     = run ? rd_word : '0;
  assign op       = op_e'(word[27:25]);
  assign sel24    = word[24];
  assign nop_n    = word[NOP_W-1:0];
  assign call_n   = word[9 +: CNT_W];
  assign tgt      = word[PC_W-1:0];
  assign pc_inc   = pc_q + PC_W'(1);
  assign push_cnt = (call_n == '0) ? '0 : call_n - CNT_W'(1);

  // next-state sequencing
  always_comb begin
    pc_d   = pc_q;
    busy_d = busy_q;
    left_d = left_q;
    push   = 1'b0;
    pop    = 1'b0;
    dec    = 1'b0;
    case (op)
      OP_NOP: begin
        if (busy_q) begin
          if (left_q == '0) begin
            busy_d = 1'b0;
            pc_d   = pc_inc;
          end else begin
            left_d = left_q - NOP_W'(1);
          end
        end else if (nop_n <= NOP_W'(1)) begin
          pc_d = pc_inc;
        end else begin
          busy_d = 1'b1;
          left_d = nop_n - NOP_W'(2);
        end
      end
      OP_CALL: begin
        push = 1'b1;
        pc_d = tgt;
      end
      OP_BRANCH: begin
        if (!sel24) begin
          pc_d = tgt;
        end else if (st_empty) begin
          pc_d = pc_inc;
        end else if (top_cnt != '0) begin
          dec  = 1'b1;
          pc_d = top_tgt;
        end else begin
          pop  = 1'b1;
          pc_d = top_ret;
        end
      end
      default: pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (!run) begin
      pc_q   <= '0;
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      pc_q   <= pc_d;
      busy_q <= busy_d;
      left_q <= left_d;
    end
  end

  // outputs
  assign hsync     = word[31];
  assign vsync     = word[30];
  assign active    = word[29];
  assign aux       = word[28];
  assign irq       = (op == OP_EVENT) && !sel24;
  assign pix_valid = (op == OP_EVENT) && sel24;
  assign pix_data  = pix_valid ? word[PIX_W-1:0] : '0;
  assign cmd_valid = word[27];
  assign cmd_kind  = cmd_valid ? word[26:25] : 2'b00;
  assign cmd_arg   = cmd_valid ? word[ARG_W-1:0] : '0;

  // R1
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> pc_q == '0);

  // R3
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && busy_q && left_q != '0) |=> $stable(pc_q));

  // R4
  call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_CALL) |=> pc_q == $past(tgt));

  // R7
  jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_BRANCH && !sel24) |=> pc_q == $past(tgt));
endmodule

// File: tb/raster_seq_tb.sv
module raster_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_we;
  logic [8:0]  ld_addr;
  logic [31:0] ld_data;
  logic        hsync, vsync, active, aux, irq, pix_valid, cmd_valid;
  logic [23:0] pix_data;
  logic [1:0]  cmd_kind;
  logic [24:0] cmd_arg;

  always #5 clk = ~clk;

  raster_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .hsync(hsync), .vsync(vsync), .active(active), .aux(aux), .irq(irq),
    .pix_valid(pix_valid), .pix_data(pix_data), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_arg(cmd_arg)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] img [512];
  int  rel_edges;
  int  m_pc;
  int  hold_cyc;
  int  st_ret[$];
  int  st_tgt[$];
  int  st_rem[$];
  string ctx = "R2";
  bit  post_ign = 1'b0;

  function automatic logic [31:0] mk(input logic [3:0] sig, input int op, input int pay);
    return {sig, 3'(op), 25'(pay)};
  endfunction

  task automatic model_step();
    logic [31:0] w;
    int n;
    w = img[m_pc];
    case (int'(w[27:25]))
      0: begin
        n = int'(w[12:0]);
        if (n == 0) n = 1;
        hold_cyc++;
        if (hold_cyc >= n) begin hold_cyc = 0; m_pc++; end
        ctx = "R3";
      end
      1: begin
        n = int'(w[22:9]);
        if (n == 0) n = 1;
        st_ret.push_back((m_pc + 1) % 512);
        st_tgt.push_back(int'(w[8:0]));
        st_rem.push_back(n);
        m_pc = int'(w[8:0]);
        ctx = (st_ret.size() == 4) ? "R6" : "R4";
      end
      2: begin
        if (!w[24]) begin
          m_pc = int'(w[8:0]);
          ctx = "R7";
        end else if (st_ret.size() == 0) begin
          m_pc++;
          ctx = "R5";
        end else begin
          st_rem[st_rem.size()-1] = st_rem[st_rem.size()-1] - 1;
          if (st_rem[st_rem.size()-1] > 0) begin
            m_pc = st_tgt[st_tgt.size()-1];
            ctx = "R5";
          end else begin
            m_pc = st_ret.pop_back();
            void'(st_tgt.pop_back());
            void'(st_rem.pop_back());
            ctx = "R4";
          end
        end
      end
      default: begin m_pc++; ctx = "R2"; end
    endcase
    m_pc = m_pc % 512;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rel_edges = 0; m_pc = 0; hold_cyc = 0;
      st_ret.delete(); st_tgt.delete(); st_rem.delete();
    end else begin
      if (rel_edges >= 2) model_step();
      if (rel_edges < 2) rel_edges++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    logic [31:0] w;
    logic e_irq, e_pv, e_cv;
    string tag;
    if (!done && rst_n !== 1'bx) begin
      if (rel_edges < 2) begin
        w = '0;
        tag = "R1";
      end else begin
        w = img[m_pc];
        tag = (post_ign && m_pc == 3) ? "R11" : ctx;
      end
      e_irq = (w[27:25] == 3'd3) && !w[24];
      e_pv  = (w[27:25] == 3'd3) && w[24];
      e_cv  = w[27];
      chk({"R2/", tag}, 64'({hsync, vsync, active, aux}), 64'(w[31:28]));
      chk((rel_edges < 2) ? "R1" : "R8", 64'(irq), 64'(e_irq));
      chk((rel_edges < 2) ? "R1" : "R9", 64'({pix_valid, pix_data}),
          64'({e_pv, e_pv ? w[23:0] : 24'h0}));
      chk((rel_edges < 2) ? "R1" : "R10", 64'({cmd_valid, cmd_kind, cmd_arg}),
          64'({e_cv, e_cv ? w[26:25] : 2'b00, e_cv ? w[24:0] : 25'h0}));
    end
  end

  task automatic load(input int a, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 9'(a); ld_data = d;
    img[a] = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) img[i] = '0;
    rst_n = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    // program A: hold, nested call x3 (inner x2), strobes, zero-count hold, jump
    load(0,  mk(4'b1000, 0, 3));                  // R3
    load(1,  mk(4'b1100, 1, (3 << 9) | 20));      // R4
    load(2,  mk(4'b0010, 3, 0));                  // R8
    load(3,  mk(4'b0001, 3, (1 << 24) | 24'hA5C3E1)); // R9
    load(4,  mk(4'b1010, 4, 25'h1ABCDEF));        // R10
    load(5,  mk(4'b0100, 5, 25'h0280));
    load(6,  mk(4'b0110, 6, 25'h0140));
    load(7,  mk(4'b1111, 7, 25'h0280));
    load(8,  mk(4'b0110, 0, 0));                  // R3 count 0
    load(9,  mk(4'b0101, 2, 0));                  // R7
    load(20, mk(4'b0011, 0, 2));
    load(21, mk(4'b1110, 1, (2 << 9) | 30));
    load(22, mk(4'b0111, 2, 1 << 24));            // R5
    load(30, mk(4'b1001, 3, (1 << 24) | 24'h123456));
    load(31, mk(4'b1011, 2, 1 << 24));
    run_cycles(3);
    rst_n = 1'b1;                                 // R1
    run_cycles(60);
    // R11: write while running must be ignored
    ld_we = 1'b1; ld_addr = 9'd3; ld_data = mk(4'b1111, 0, 5);
    @(negedge clk);
    ld_we = 1'b0;
    post_ign = 1'b1;
    run_cycles(200);
    post_ign = 1'b0;
    // program B: zero-count call, four-level nesting
    rst_n = 1'b0;
    run_cycles(2);
    load(0,  mk(4'b1000, 1, (0 << 9) | 40));      // R4 count 0
    load(1,  mk(4'b0100, 1, (2 << 9) | 50));
    load(2,  mk(4'b0010, 2, 0));
    load(40, mk(4'b0001, 0, 1));
    load(41, mk(4'b1001, 2, 1 << 24));
    load(50, mk(4'b1100, 1, (2 << 9) | 60));
    load(51, mk(4'b0011, 2, 1 << 24));
    load(60, mk(4'b1010, 1, (1 << 9) | 70));
    load(61, mk(4'b0101, 2, 1 << 24));
    load(70, mk(4'b1110, 1, (2 << 9) | 80));      // R6 fourth level
    load(71, mk(4'b0110, 2, 1 << 24));
    load(80, mk(4'b0111, 3, 0));
    load(81, mk(4'b1011, 2, 1 << 24));
    rst_n = 1'b1;
    run_cycles(300);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule